// File: doc/BRIEF.md
# MSI-X Vector Table with Pending Replay

This block holds the device-side message table and pending-bit array for a small set of message-signalled interrupt vectors. Software reaches both through one register port that takes aligned 32-bit or 64-bit accesses. Each vector entry holds a 64-bit message address, a 32-bit message data word and a per-vector mask bit. The function-level enable and function mask come in as inputs from the message control register. Each vector has one interrupt-request input.

A request on a vector that can be delivered launches a message (address, data and vector number) on a valid/ready output. A request on a vector that is blocked, by its own mask, by the function mask or by a cleared enable, sets that vector's pending bit. When the block is lifted, pending vectors are launched in ascending vector order, one per cycle while the receiver accepts. Each pending bit clears as its message launches. After reset every vector is masked, so software only ever unmasks.

The message side is a two-state machine. ST_IDLE means no message is offered. ST_SEND means a message is held on the output. The transitions are: ST_IDLE to ST_SEND on launch; ST_SEND to ST_SEND on acceptance with a new launch, or while the receiver stalls; ST_SEND to ST_IDLE on acceptance with nothing left to launch.

Top module: `msix_table_ctrl`

## Requirements
- R1: After reset no message is offered, every pending bit reads 0, every entry's address and data read 0, and every vector's control word reads 1 (masked).
- R2: Entry i starts at byte offset 16*i from the table base. Dword 0 is address low, dword 1 is address high, dword 2 is data, and dword 3 is vector control. Only control bit 0 (the mask) is stored; the other control bits read 0.
- R3: An aligned 64-bit access at entry offset 0 covers address low (bits 31:0) and address high (bits 63:32). At offset 8 it covers data (bits 31:0) and control (bits 63:32).
- R4: A request on a vector whose mask bit is 1 sends no message and sets pending bit i. Bit i is vector i in the low dword at the pending-array base.
- R5: When a masked vector with its pending bit set is unmasked, its message is offered one cycle after the write cycle, and its pending bit reads 0 afterwards.
- R6: While the function mask is 1, no vector sends, whatever its own mask, and requests set pending bits. Clearing the function mask offers all pending vectors in ascending order on consecutive cycles while msg_ready is 1.
- R7: While the function enable is 0, no vector sends and requests set pending bits. Setting it releases them.
- R8: With the output idle and nothing else owed, a request on a deliverable vector offers its message on the next cycle with that entry's address and data, and sets no pending bit.
- R9: An offered message holds its vector, address and data stable until msg_ready is 1.
- R10: Writes to the pending array have no effect.
- R11: The table and pending-array locations come from 32-bit offset register values whose bits 31:3 give the byte offset unshifted; bits 2:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_enable | input | 1 | Function-level message enable |
| fn_mask | input | 1 | Function-wide mask |
| irq_req | input | NUM_VEC | One request pulse per vector |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_qword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| acc_rdata | output | 64 | Read data, valid one cycle after the read |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | $clog2(NUM_VEC) | Vector number of the message |

## Verification
The bench targets the unmask of a pending vector. A design that forgot the pending bit would never send, and one that kept it would leave it set after the send. It masks the function, gathers requests on all vectors and then releases them. A wrong priority encoder would send out of order, and a design that takes one idle cycle between messages would be a cycle late. It also writes all ones to a control word and zero to the pending array: a design that stores extra control bits or lets the pending array be written would show it on readback. Random phases change the enable, the masks, the requests and the receiver stalls every cycle and compare every output cycle with a reference model. Dropped, duplicated or changed messages under backpressure show up there.

// File: rtl/msix_pkg.sv
package msix_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } msg_state_e;

    localparam int ENTRY_BYTES = 16;
    localparam int PBA_BYTES   = 8;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table #(
    parameter int NUM_VEC = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [3:0]         wr_mask,
    input  logic [127:0]       wr_line,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [127:0]       rd_line,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data,
    output logic [NUM_VEC-1:0] vec_mask
);
    logic [31:0] lo_q   [NUM_VEC];
    logic [31:0] hi_q   [NUM_VEC];
    logic [31:0] data_q [NUM_VEC];
    logic [NUM_VEC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
                data_q[i] <= '0;
            end
            mask_q <= '1;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    if (wr_mask[0]) lo_q[i]   <= wr_line[31:0];
                    if (wr_mask[1]) hi_q[i]   <= wr_line[63:32];
                    if (wr_mask[2]) data_q[i] <= wr_line[95:64];
                    if (wr_mask[3]) mask_q[i] <= wr_line[96];
                end
            end
        end
    end

    assign rd_line  = {31'b0, mask_q[rd_idx], data_q[rd_idx], hi_q[rd_idx], lo_q[rd_idx]};
    assign sel_addr = {hi_q[sel_idx], lo_q[sel_idx]};
    assign sel_data = data_q[sel_idx];
    assign vec_mask = mask_q;
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb #(
    parameter int NUM_VEC = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req,
    input  logic [NUM_VEC-1:0] deliv,
    input  logic               launch_ok,
    output logic               launch,
    output logic [IDX_W-1:0]   sel,
    output logic [NUM_VEC-1:0] pending
);
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] owed;
    logic [NUM_VEC-1:0] cand;
    logic [NUM_VEC-1:0] clr;
    logic               found;

    assign owed = pend_q | req;
    assign cand = owed & deliv;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign launch = launch_ok && found;
    assign clr    = launch ? (NUM_VEC'(1) << sel) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= owed & ~clr;
    end

    assign pending = pend_q;
endmodule

// File: rtl/msix_table_ctrl.sv
module msix_table_ctrl
    import msix_pkg::*;
#(
    parameter int          NUM_VEC     = 4,
    parameter int          ADDR_W      = 12,
    parameter logic [31:0] TBL_OFS_REG = 32'h0000_0000,
    parameter logic [31:0] PBA_OFS_REG = 32'h0000_0800
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fn_enable,
    input  logic                       fn_mask,
    input  logic [NUM_VEC-1:0]         irq_req,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic                       acc_qword,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [63:0]                acc_wdata,
    output logic [63:0]                acc_rdata,
    output logic                       msg_valid,
    input  logic                       msg_ready,
    output logic [63:0]                msg_addr,
    output logic [31:0]                msg_data,
    output logic [$clog2(NUM_VEC)-1:0] msg_vec
);
    localparam int          IDX_W    = $clog2(NUM_VEC);
    localparam logic [31:0] TBL_BASE = {TBL_OFS_REG[31:3], 3'b000};
    localparam logic [31:0] PBA_BASE = {PBA_OFS_REG[31:3], 3'b000};
    localparam logic [31:0] TBL_END  = TBL_BASE + 32'(NUM_VEC * ENTRY_BYTES);
    localparam logic [31:0] PBA_END  = PBA_BASE + 32'(PBA_BYTES);

    // Register-port decode
    logic [31:0]  addr32, tbl_off, pba_off;
    logic         hit_tbl, hit_pba, aligned;
    logic [1:0]   dw;
    logic [IDX_W-1:0] acc_idx;
    logic [3:0]   wr_mask;
    logic [127:0] wr_line, rd_line;
    logic [63:0]  rd_val, pba_ext, rdata_q;

    assign addr32  = 32'(acc_addr);
    assign tbl_off = addr32 - TBL_BASE;
    assign pba_off = addr32 - PBA_BASE;
    assign hit_tbl = (addr32 >= TBL_BASE) && (addr32 < TBL_END);
    assign hit_pba = (addr32 >= PBA_BASE) && (addr32 < PBA_END);
    assign aligned = acc_qword ? (acc_addr[2:0] == 3'b000) : (acc_addr[1:0] == 2'b00);
    assign dw      = tbl_off[3:2];
    assign acc_idx = tbl_off[4 +: IDX_W];
    assign wr_mask = acc_qword ? (4'b0011 << dw) : (4'b0001 << dw);
    assign wr_line = acc_qword ? {2{acc_wdata}} : {4{acc_wdata[31:0]}};
    assign pba_ext = 64'(pending);

    // Message side
    msg_state_e         state_q, state_d;
    logic [NUM_VEC-1:0] vec_mask, pending, deliv;
    logic               launch, launch_ok;
    logic [IDX_W-1:0]   sel;
    logic [63:0]        sel_addr, addr_q;
    logic [31:0]        sel_data, data_q;
    logic [IDX_W-1:0]   vec_q;

    msix_vec_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_valid && acc_write && hit_tbl && aligned),
        .wr_idx   (acc_idx),
        .wr_mask  (wr_mask),
        .wr_line  (wr_line),
        .rd_idx   (acc_idx),
        .rd_line  (rd_line),
        .sel_idx  (sel),
        .sel_addr (sel_addr),
        .sel_data (sel_data),
        .vec_mask (vec_mask)
    );

    generate
        for (genvar g = 0; g < NUM_VEC; g++) begin : g_deliv
            assign deliv[g] = fn_enable && !fn_mask && !vec_mask[g];
        end
    endgenerate

    assign launch_ok = (state_q == ST_IDLE) || msg_ready;

    msix_pend_arb #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .deliv     (deliv),
        .launch_ok (launch_ok),
        .launch    (launch),
        .sel       (sel),
        .pending   (pending)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_SEND;
            ST_SEND: if (msg_ready && !launch) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (launch) begin
            vec_q  <= sel;
            addr_q <= sel_addr;
            data_q <= sel_data;
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_tbl && aligned) begin
            rd_val[31:0] = rd_line[{dw, 5'b0} +: 32];
            if (acc_qword) rd_val[63:32] = rd_line[{dw[1], 1'b1, 5'b0} +: 32];
        end else if (hit_pba && aligned) begin
            if (acc_qword)       rd_val = pba_ext;
            else if (pba_off[2]) rd_val[31:0] = pba_ext[63:32];
            else                 rd_val[31:0] = pba_ext[31:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     rdata_q <= '0;
        else if (acc_valid && !acc_write) rdata_q <= rd_val;
    end

    assign acc_rdata = rdata_q;
    assign msg_valid = (state_q == ST_SEND);
    assign msg_vec   = vec_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;
endmodule

// File: rtl/msix_table_ctrl_chk.sv
module msix_table_ctrl_chk #(
    parameter int NUM_VEC = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fn_enable,
    input logic               fn_mask,
    input logic [NUM_VEC-1:0] irq_req,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic [NUM_VEC-1:0] pending,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [IDX_W-1:0]   msg_vec,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data
);
    // R4: a request on a masked vector lands in its pending bit
    p_masked_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & vec_mask) != '0) |=>
        ((pending & $past(irq_req & vec_mask)) == $past(irq_req & vec_mask)));

    // R4: a freshly offered message never comes from a vector that was masked
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid || msg_ready) |=>
        (!msg_valid || ((($past(vec_mask) >> msg_vec) & NUM_VEC'(1)) == '0)));

    // R5: pending bit of a launched vector is clear once it is offered
    p_pba_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid || msg_ready) |=> (!msg_valid || !pending[msg_vec]));

    // R6/R7: a launch only happens while the function is enabled and unmasked
    p_fn_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid || msg_ready) |=> (!msg_valid || $past(fn_enable && !fn_mask)));

    // R9: stalled message holds still
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
        (msg_valid && $stable(msg_vec) && $stable(msg_addr) && $stable(msg_data)));
endmodule

bind msix_table_ctrl msix_table_ctrl_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fn_enable (fn_enable),
    .fn_mask   (fn_mask),
    .irq_req   (irq_req),
    .vec_mask  (vec_mask),
    .pending   (pending),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_vec   (msg_vec),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/msix_table_ctrl_bench.sv
module msix_table_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV   = 4;
    localparam int AW   = 12;
    localparam int TBL  = 32'h100;
    localparam int PBA  = 32'h800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fn_enable = 1'b0, fn_mask = 1'b0;
    logic [NV-1:0] irq_req = '0;
    logic          acc_valid = 1'b0, acc_write = 1'b0, acc_qword = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [63:0]   acc_wdata = '0, acc_rdata;
    logic          msg_valid, msg_ready = 1'b0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic [1:0]    msg_vec;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    bit [31:0] m_lo [NV], m_hi [NV], m_dat [NV];
    bit        m_msk [NV];
    bit [NV-1:0] m_pba;
    bit          m_busy;
    bit [1:0]    m_vec;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msix_table_ctrl #(
        .NUM_VEC(NV), .ADDR_W(AW),
        .TBL_OFS_REG(32'h0000_0104), .PBA_OFS_REG(32'h0000_0805)
    ) u_msix_table_ctrl (
        .clk(clk), .rst_n(rst_n), .fn_enable(fn_enable), .fn_mask(fn_mask),
        .irq_req(irq_req), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_qword(acc_qword), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ent(input int v, input int dwo);
        return TBL + 16 * v + dwo;
    endfunction

    task automatic bus_wr(input int addr, input logic [63:0] d, input bit q);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_qword = q;
        acc_addr = AW'(addr); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_qword = 1'b0;
    endtask

    task automatic bus_rd(input int addr, input bit q, output logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_qword = q; acc_addr = AW'(addr);
        @(negedge clk);
        acc_valid = 1'b0; acc_qword = 1'b0;
        d = acc_rdata;
    endtask

    task automatic set_ctrl(input int v, input bit m);
        bus_wr(ent(v, 12), {32'b0, 31'b0, m}, 1'b0);
        m_msk[v] = m;
    endtask

    task automatic chk_msg(input string req, input int v);
        chk(msg_valid === 1'b1, req, "msg_valid", 64'(msg_valid), 64'd1);
        chk(msg_vec === 2'(v), req, "msg_vec", 64'(msg_vec), 64'(v));
        chk(msg_addr === {m_hi[v], m_lo[v]}, req, "msg_addr", msg_addr, {m_hi[v], m_lo[v]});
        chk(msg_data === m_dat[v], req, "msg_data", 64'(msg_data), 64'(m_dat[v]));
    endtask

    // One cycle against the reference model; called just after a falling edge
    task automatic rnd_cycle(input bit en, input bit fm, input bit [NV-1:0] rq, input bit rdy);
        bit [NV-1:0] deliv, cand;
        bit          launch;
        int          s;
        fn_enable = en; fn_mask = fm; irq_req = rq; msg_ready = rdy;
        for (int i = 0; i < NV; i++) deliv[i] = en && !fm && !m_msk[i];
        cand = (m_pba | rq) & deliv;
        launch = (!m_busy || rdy) && (cand != '0);
        s = 0;
        for (int i = NV - 1; i >= 0; i--) if (cand[i]) s = i;
        m_pba = (m_pba | rq) & ~(launch ? (NV'(1) << s) : NV'(0));
        m_busy = launch ? 1'b1 : (m_busy && !rdy);
        if (launch) m_vec = 2'(s);
        @(negedge clk);
        irq_req = '0;
        chk(msg_valid === m_busy, "R6", "random msg_valid", 64'(msg_valid), 64'(m_busy));
        if (m_busy) chk_msg("R8", int'(m_vec));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] rd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NV; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_dat[i] = '0; m_msk[i] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(msg_valid === 1'b0, "R1", "msg_valid after reset", 64'(msg_valid), 64'd0);
        for (int v = 0; v < NV; v++) begin
            bus_rd(ent(v, 12), 1'b0, rd);
            chk(rd === 64'd1, "R1", "ctrl after reset", rd, 64'd1);
            bus_rd(ent(v, 0), 1'b1, rd);
            chk(rd === 64'd0, "R1", "address after reset", rd, 64'd0);
        end
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'd0, "R1", "pending after reset", rd, 64'd0);

        // R2/R3: program entries with random contents, mixing access widths
        for (int v = 0; v < NV; v++) begin
            m_lo[v] = $urandom; m_hi[v] = $urandom; m_dat[v] = $urandom;
            bus_wr(ent(v, 0), {m_hi[v], m_lo[v]}, 1'b1);
            bus_wr(ent(v, 8), {32'b0, m_dat[v]}, 1'b0);
        end
        for (int v = 0; v < NV; v++) begin
            bus_rd(ent(v, 0), 1'b0, rd);
            chk(rd === 64'(m_lo[v]), "R2", "address low dword", rd, 64'(m_lo[v]));
            bus_rd(ent(v, 4), 1'b0, rd);
            chk(rd === 64'(m_hi[v]), "R2", "address high dword", rd, 64'(m_hi[v]));
            bus_rd(ent(v, 8), 1'b0, rd);
            chk(rd === 64'(m_dat[v]), "R2", "data dword", rd, 64'(m_dat[v]));
            bus_rd(ent(v, 0), 1'b1, rd);
            chk(rd === {m_hi[v], m_lo[v]}, "R3", "address qword", rd, {m_hi[v], m_lo[v]});
        end
        bus_wr(ent(3, 12), 64'hFFFF_FFFF, 1'b0);
        bus_rd(ent(3, 12), 1'b0, rd);
        chk(rd === 64'd1, "R2", "ctrl stores only bit 0", rd, 64'd1);
        bus_rd(ent(3, 8), 1'b1, rd);
        chk(rd === {32'd1, m_dat[3]}, "R3", "data+ctrl qword", rd, {32'd1, m_dat[3]});

        // R4: masked request goes to pending
        fn_enable = 1'b1; fn_mask = 1'b0; msg_ready = 1'b1;
        @(negedge clk);
        irq_req = 4'b0100;
        @(negedge clk);
        irq_req = '0;
        chk(msg_valid === 1'b0, "R4", "no message for masked vector", 64'(msg_valid), 64'd0);
        @(negedge clk);
        chk(msg_valid === 1'b0, "R4", "still no message", 64'(msg_valid), 64'd0);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'h4, "R4", "pending bit 2", rd, 64'h4);

        // R10: pending array ignores writes
        bus_wr(PBA, 64'h0, 1'b0);
        bus_wr(PBA, 64'hF, 1'b1);
        bus_rd(PBA, 1'b1, rd);
        chk(rd === 64'h4, "R10", "pending unchanged by writes", rd, 64'h4);

        // R5: unmask replays pending message
        set_ctrl(2, 1'b0);
        @(negedge clk);
        chk_msg("R5", 2);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'h0, "R5", "pending cleared after replay", rd, 64'h0);
        chk(msg_valid === 1'b0, "R5", "single replay", 64'(msg_valid), 64'd0);

        // R8 + R9: immediate delivery, held under backpressure
        msg_ready = 1'b0;
        irq_req = 4'b0100;
        @(negedge clk);
        irq_req = '0;
        chk_msg("R8", 2);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'h0, "R8", "no pending bit on direct delivery", rd, 64'h0);
        @(negedge clk);
        chk_msg("R9", 2);
        msg_ready = 1'b1;
        @(negedge clk);
        chk(msg_valid === 1'b0, "R9", "released after accept", 64'(msg_valid), 64'd0);

        // R6: function mask overrides, then ascending back-to-back release
        set_ctrl(0, 1'b0); set_ctrl(1, 1'b0); set_ctrl(3, 1'b0);
        @(negedge clk);
        fn_mask = 1'b1;
        irq_req = 4'b1011;
        @(negedge clk);
        irq_req = 4'b0100;
        @(negedge clk);
        irq_req = '0;
        chk(msg_valid === 1'b0, "R6", "function mask blocks", 64'(msg_valid), 64'd0);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'hF, "R6", "all pending under function mask", rd, 64'hF);
        fn_mask = 1'b0;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            chk_msg("R6", k);
        end
        @(negedge clk);
        chk(msg_valid === 1'b0, "R6", "idle after release", 64'(msg_valid), 64'd0);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'h0, "R6", "pending drained", rd, 64'h0);

        // R7: disabled function holds requests
        fn_enable = 1'b0;
        irq_req = 4'b0010;
        @(negedge clk);
        irq_req = '0;
        chk(msg_valid === 1'b0, "R7", "disabled blocks", 64'(msg_valid), 64'd0);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'h2, "R7", "pending while disabled", rd, 64'h2);
        fn_enable = 1'b1;
        @(negedge clk);
        chk_msg("R7", 1);
        @(negedge clk);
        chk(msg_valid === 1'b0, "R7", "idle after release", 64'(msg_valid), 64'd0);

        // R11: offsets used unshifted with low bits ignored
        bus_rd(32'h800, 1'b0, rd);
        chk(rd === 64'h0, "R11", "pending base at 0x800", rd, 64'h0);
        bus_rd(32'h10C, 1'b0, rd);
        chk(rd === 64'(m_msk[0]), "R11", "table base at 0x100", rd, 64'(m_msk[0]));

        // Random phase against the reference model
        set_ctrl(3, 1'b1);
        m_pba = '0; m_busy = 1'b0; m_vec = '0;
        for (int c = 0; c < 600; c++)
            rnd_cycle(($urandom % 8) != 0, ($urandom % 5) == 0,
                      NV'($urandom) & NV'($urandom), ($urandom % 3) != 0);
        for (int c = 0; c < 12; c++) rnd_cycle(1'b1, 1'b0, '0, 1'b1);
        bus_rd(PBA, 1'b0, rd);
        chk(rd === 64'(m_pba), "R4", "pending after random phase", rd, 64'(m_pba));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule